// File: doc/BRIEF.md
# Unified Pointer Aperture Translator

This block turns a 64-bit shader pointer into the form the memory system expects: a 48-bit address plus one select bit. The select bit picks the translation space, 0 for the GPU page tables and 1 for the host page tables. The block also returns a memory-type code and a fault flag. The per-process configuration arrives on plain register inputs:

- a compute-ATC bit and a 32-bit-pointer bit, which together pick the addressing mode;
- bounds for the GPU-table aperture;
- bounds and a memory type for a spare aperture;
- a default memory type.

A draw-type request always uses the GPU-table 64-bit mode, whatever the compute-ATC bit says.

The pointer is first narrowed to 32 bits if the 32-bit system mode is active. It is then compared against both apertures and checked against the non-canonical hole. A pointer inside the GPU-table aperture is rebased to an offset from that aperture's base and sent to the GPU tables. Any other canonical pointer goes to the mode's default space unchanged. The result appears one clock after the request, together with a delayed valid.

Top module: `ptr_aperture_xlate`

## Requirements
- R1: The mode is the GPU-table 64-bit mode when `in_draw`=1 or `cfg_compute_atc`=0, and `cfg_ptr32` has no effect then. With `cfg_compute_atc`=1 and `in_draw`=0, `cfg_ptr32`=0 selects the 64-bit system mode and `cfg_ptr32`=1 selects the 32-bit system mode.
- R2: A pointer whose bits 63..47 are neither all zero nor all one, and that misses the GPU-table aperture, gives `out_fault`=1, `out_addr`=0 and `out_sel` equal to the mode's default.
- R3: An aperture spans from {hi,16'h0000} to {hi,16'hFFFF}, where hi is the 48-bit register value, and both ends are inclusive. One below the base and one above the limit are outside.
- R4: A pointer inside the GPU-table aperture gives `out_sel`=0 and `out_addr` = (pointer − base)[47:0].
- R5: A rebased offset greater than 2^40−1 sets `out_fault`=1. An offset of exactly 2^40−1 does not.
- R6: A canonical pointer that misses the GPU-table aperture gives `out_addr` = pointer[47:0] and `out_fault`=0. `out_sel` is 1 in both system modes and 0 in the GPU-table mode.
- R7: `out_mtype` equals `cfg_spare_mtype` when the pointer lies inside the spare aperture, and `cfg_dflt_mtype` otherwise. In the 32-bit system mode the spare aperture never matches.
- R8: In the 32-bit system mode only pointer bits 31..0 are used, zero-extended to 64 bits, before any other test.
- R9: `out_valid` equals `in_valid` delayed by one clock, and it is 0 during reset.
- R10: While `in_valid` is 0, `out_sel`, `out_addr`, `out_mtype` and `out_fault` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ptr | input | 64 | Shader pointer |
| in_draw | input | 1 | Draw-type request; forces the GPU-table 64-bit mode |
| cfg_compute_atc | input | 1 | Compute-ATC bit: default space is the host tables |
| cfg_ptr32 | input | 1 | 32-bit pointer select |
| cfg_vm_base_hi | input | 48 | GPU-table aperture base, bits 63..16 |
| cfg_vm_limit_hi | input | 48 | GPU-table aperture limit, bits 63..16 |
| cfg_spare_base_hi | input | 48 | Spare aperture base, bits 63..16 |
| cfg_spare_limit_hi | input | 48 | Spare aperture limit, bits 63..16 |
| cfg_spare_mtype | input | 3 | Memory type for spare-aperture hits |
| cfg_dflt_mtype | input | 3 | Memory type for all other pointers |
| out_valid | output | 1 | Result valid |
| out_sel | output | 1 | Translation space: 0 GPU tables, 1 host tables |
| out_addr | output | 48 | Translation address |
| out_mtype | output | 3 | Memory type |
| out_fault | output | 1 | Hole access or offset overflow |

## Verification
A wrong mode decode shows one cycle after the request as a flipped `out_sel` on every canonical pointer that misses the aperture. It shows that way in the draw cases and in the cases where `cfg_ptr32` should be ignored. An off-by-one in a bound comparison shows only at the exact base, base−1, limit and limit+1 pointers, so the bench drives each of them. There a faulty bound turns a rebased address into a hole fault, or the reverse. A lost data clock enable shows in the cycles after valid drops, as outputs that change while no request is present.

// File: rtl/ptr_ap_pkg.sv
package ptr_ap_pkg;
  typedef enum logic [1:0] {
    MODE_GVM64 = 2'd0,
    MODE_SYS64 = 2'd1,
    MODE_SYS32 = 2'd2
  } ap_mode_e;
endpackage

// File: rtl/ap_mode_dec.sv
module ap_mode_dec
  import ptr_ap_pkg::*;
(
  input  logic     draw,
  input  logic     compute_atc,
  input  logic     ptr32,
  output ap_mode_e mode,
  output logic     dflt_sel
);
  always_comb begin
    if (draw || !compute_atc) mode = MODE_GVM64;  // ptr32 ignored here
    else if (ptr32)           mode = MODE_SYS32;
    else                      mode = MODE_SYS64;
    dflt_sel = (mode != MODE_GVM64);
  end
endmodule

// File: rtl/ap_window.sv
module ap_window #(
  parameter int PW   = 64,
  parameter int GRAN = 16,
  localparam int HW  = PW - GRAN
) (
  input  logic [PW-1:0] addr,
  input  logic [HW-1:0] base_hi,
  input  logic [HW-1:0] limit_hi,
  output logic [PW-1:0] lo_bound,
  output logic          hit
);
  logic [PW-1:0] hi_bound;
  always_comb begin
    lo_bound = {base_hi, {GRAN{1'b0}}};
    hi_bound = {limit_hi, {GRAN{1'b1}}};
    hit      = (addr >= lo_bound) && (addr <= hi_bound);
  end
endmodule

// File: rtl/ptr_aperture_xlate.sv
module ptr_aperture_xlate
  import ptr_ap_pkg::*;
#(
  parameter int PW      = 64,
  parameter int OUT_W   = 48,
  parameter int GRAN    = 16,
  parameter int SPAN_W  = 40,
  parameter int NARROW  = 32,
  parameter int MT_W    = 3,
  localparam int HW     = PW - GRAN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PW-1:0]    in_ptr,
  input  logic             in_draw,
  input  logic             cfg_compute_atc,
  input  logic             cfg_ptr32,
  input  logic [HW-1:0]    cfg_vm_base_hi,
  input  logic [HW-1:0]    cfg_vm_limit_hi,
  input  logic [HW-1:0]    cfg_spare_base_hi,
  input  logic [HW-1:0]    cfg_spare_limit_hi,
  input  logic [MT_W-1:0]  cfg_spare_mtype,
  input  logic [MT_W-1:0]  cfg_dflt_mtype,
  output logic             out_valid,
  output logic             out_sel,
  output logic [OUT_W-1:0] out_addr,
  output logic [MT_W-1:0]  out_mtype,
  output logic             out_fault
);
  localparam int TOP_W = PW - OUT_W + 1;  // bits that must agree for canonical

  ap_mode_e      mode;
  logic          dflt_sel;
  logic [PW-1:0] eff_ptr;
  logic [PW-1:0] vm_lo, sp_lo, offset;
  logic          vm_hit, sp_hit_raw;
  logic [TOP_W-1:0] top_bits;
  logic          canonical;

  logic             sel_d, fault_d;
  logic [OUT_W-1:0] addr_d;
  logic [MT_W-1:0]  mtype_d;

  ap_mode_dec u_mode (
    .draw(in_draw), .compute_atc(cfg_compute_atc), .ptr32(cfg_ptr32),
    .mode(mode), .dflt_sel(dflt_sel)
  );

  always_comb begin
    if (mode == MODE_SYS32) eff_ptr = {{(PW-NARROW){1'b0}}, in_ptr[NARROW-1:0]};
    else                    eff_ptr = in_ptr;
  end

  ap_window #(.PW(PW), .GRAN(GRAN)) u_vm_win (
    .addr(eff_ptr), .base_hi(cfg_vm_base_hi), .limit_hi(cfg_vm_limit_hi),
    .lo_bound(vm_lo), .hit(vm_hit)
  );

  ap_window #(.PW(PW), .GRAN(GRAN)) u_sp_win (
    .addr(eff_ptr), .base_hi(cfg_spare_base_hi), .limit_hi(cfg_spare_limit_hi),
    .lo_bound(sp_lo), .hit(sp_hit_raw)
  );

  // next-state logic
  always_comb begin
    top_bits  = eff_ptr[PW-1:OUT_W-1];
    canonical = (&top_bits) || !(|top_bits);
    offset    = eff_ptr - vm_lo;
    mtype_d   = (sp_hit_raw && (mode != MODE_SYS32)) ? cfg_spare_mtype : cfg_dflt_mtype;
    if (vm_hit) begin
      sel_d   = 1'b0;
      addr_d  = offset[OUT_W-1:0];
      fault_d = |offset[PW-1:SPAN_W];
    end else if (!canonical) begin
      sel_d   = dflt_sel;
      addr_d  = '0;
      fault_d = 1'b1;
    end else begin
      sel_d   = dflt_sel;
      addr_d  = eff_ptr[OUT_W-1:0];
      fault_d = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_sel   <= 1'b0;
      out_addr  <= '0;
      out_mtype <= '0;
      out_fault <= 1'b0;
    end else if (in_valid) begin
      out_sel   <= sel_d;
      out_addr  <= addr_d;
      out_mtype <= mtype_d;
      out_fault <= fault_d;
    end
  end

  logic unused_ok;
  assign unused_ok = ^sp_lo;
endmodule

// File: rtl/ptr_ap_checker.sv
module ptr_ap_checker #(
  parameter int OUT_W = 48,
  parameter int MT_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_draw,
  input logic             cfg_compute_atc,
  input logic             out_valid,
  input logic             out_sel,
  input logic [OUT_W-1:0] out_addr,
  input logic [MT_W-1:0]  out_mtype,
  input logic             out_fault
);
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r9_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r10_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_addr) && $stable(out_sel) &&
                   $stable(out_mtype) && $stable(out_fault)));

  a_r1_gvm_select: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_draw || !cfg_compute_atc)) |=> !out_sel);

  a_r2_hole_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fault && out_sel) |-> (out_addr == '0));
endmodule

bind ptr_aperture_xlate ptr_ap_checker #(.OUT_W(OUT_W), .MT_W(MT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_draw(in_draw),
  .cfg_compute_atc(cfg_compute_atc), .out_valid(out_valid), .out_sel(out_sel),
  .out_addr(out_addr), .out_mtype(out_mtype), .out_fault(out_fault)
);

// File: tb/ptr_aperture_xlate_test.sv
module ptr_aperture_xlate_test;
  logic        clk = 0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] in_ptr;
  logic        in_draw, cfg_compute_atc, cfg_ptr32;
  logic [47:0] cfg_vm_base_hi, cfg_vm_limit_hi, cfg_spare_base_hi, cfg_spare_limit_hi;
  logic [2:0]  cfg_spare_mtype, cfg_dflt_mtype;
  logic        out_valid, out_sel, out_fault;
  logic [47:0] out_addr;
  logic [2:0]  out_mtype;

  typedef struct packed {
    logic        sel;
    logic [47:0] addr;
    logic [2:0]  mtype;
    logic        fault;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  exp_t  last_exp;

  always #2 clk = ~clk;  // 250 MHz

  ptr_aperture_xlate uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ptr(in_ptr),
    .in_draw(in_draw), .cfg_compute_atc(cfg_compute_atc), .cfg_ptr32(cfg_ptr32),
    .cfg_vm_base_hi(cfg_vm_base_hi), .cfg_vm_limit_hi(cfg_vm_limit_hi),
    .cfg_spare_base_hi(cfg_spare_base_hi), .cfg_spare_limit_hi(cfg_spare_limit_hi),
    .cfg_spare_mtype(cfg_spare_mtype), .cfg_dflt_mtype(cfg_dflt_mtype),
    .out_valid(out_valid), .out_sel(out_sel), .out_addr(out_addr),
    .out_mtype(out_mtype), .out_fault(out_fault)
  );

  function automatic exp_t model(input logic [63:0] p, input logic draw,
                                 input logic atc, input logic p32);
    exp_t r;
    logic is32, dsel, in_vm, in_sp, canon;
    logic [63:0] e, vb, vl, sb, sl, off;
    is32 = !draw && atc && p32;
    dsel = !draw && atc;
    e  = is32 ? {32'h0, p[31:0]} : p;
    vb = {cfg_vm_base_hi, 16'h0000};
    vl = {cfg_vm_limit_hi, 16'hFFFF};
    sb = {cfg_spare_base_hi, 16'h0000};
    sl = {cfg_spare_limit_hi, 16'hFFFF};
    in_vm = (e >= vb) && (e <= vl);
    in_sp = (e >= sb) && (e <= sl) && !is32;
    canon = (e[63:47] == 17'h0) || (e[63:47] == 17'h1FFFF);
    r.mtype = in_sp ? cfg_spare_mtype : cfg_dflt_mtype;
    if (in_vm) begin
      off = e - vb;
      r.sel = 1'b0; r.addr = off[47:0]; r.fault = (off > 64'h0000_00FF_FFFF_FFFF);
    end else if (!canon) begin
      r.sel = dsel; r.addr = '0; r.fault = 1'b1;
    end else begin
      r.sel = dsel; r.addr = e[47:0]; r.fault = 1'b0;
    end
    return r;
  endfunction

  task automatic send(input logic [63:0] p, input logic draw, input logic atc,
                      input logic p32, input string tag);
    @(negedge clk);
    in_valid = 1; in_ptr = p; in_draw = draw; cfg_compute_atc = atc; cfg_ptr32 = p32;
    exp_q.push_back(model(p, draw, atc, p32));
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      exp_t  e;
      exp_t  a;
      string t;
      a = '{sel: out_sel, addr: out_addr, mtype: out_mtype, fault: out_fault};
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R9 unexpected out_valid: actual=1 expected=0");
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        last_exp = e;
        if (a !== e) begin
          n_bad++;
          $display("FAIL %s: actual sel=%0b addr=%h mt=%0d flt=%0b expected sel=%0b addr=%h mt=%0d flt=%0b",
                   t, a.sel, a.addr, a.mtype, a.fault, e.sel, e.addr, e.mtype, e.fault);
        end
      end
    end
  end

  task automatic check_bit(input logic act, input logic expv, input string tag);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, expv);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; in_valid = 0; in_ptr = '0; in_draw = 0;
    cfg_compute_atc = 1; cfg_ptr32 = 0;
    cfg_vm_base_hi     = 48'h0001_0000_0000;  // 0x0001_0000_0000_0000
    cfg_vm_limit_hi    = 48'h0001_00FF_FFFF;  // ..._00FF_FFFF_FFFF
    cfg_spare_base_hi  = 48'h0000_7000_0000;
    cfg_spare_limit_hi = 48'h0000_7000_0FFF;
    cfg_spare_mtype = 3'd5; cfg_dflt_mtype = 3'd2;
    repeat (3) @(negedge clk);
    check_bit(out_valid, 1'b0, "R9 reset valid");
    rst_n = 1;

    // R6 default space, 64-bit system mode (R1)
    send(64'h0000_1234_5678_9ABC, 0, 1, 0, "R6 low canonical sys64");
    send(64'hFFFF_8000_0000_0010, 0, 1, 0, "R6 high canonical sys64");
    // R2 hole
    send(64'h0000_8000_0000_0000, 0, 1, 0, "R2 hole sys64");
    send(64'h1234_0000_0000_0000, 0, 0, 0, "R2 hole gvm64");
    // R3/R4 bounds of GPU-table aperture
    send(64'h0001_0000_0000_0000, 0, 1, 0, "R4 base rebase");
    send(64'h0001_00FF_FFFF_FFFF, 0, 1, 0, "R3 limit inclusive");
    send(64'h0001_0100_0000_0000, 0, 1, 0, "R3 limit+1 outside");
    send(64'h0000_FFFF_FFFF_FFFF, 0, 1, 0, "R3 base-1 outside");
    send(64'h0001_0012_3456_789A, 0, 1, 0, "R4 mid rebase");
    // R1 mode decode
    send(64'h0000_1234_5678_9ABC, 0, 0, 0, "R1 gvm64 default sel0");
    send(64'h0000_1234_5678_9ABC, 0, 0, 1, "R1 ptr32 ignored when atc=0");
    send(64'h0000_1234_5678_9ABC, 1, 1, 1, "R1 draw forces gvm64");
    send(64'hABCD_0000_1234_5678, 0, 1, 1, "R8 sys32 narrows pointer");
    // R7 spare aperture
    send(64'h0000_7000_0000_0040, 0, 1, 0, "R7 spare base hit");
    send(64'h0000_7000_0FFF_FFFF, 0, 1, 0, "R7 spare limit hit");
    send(64'h0000_7000_1000_0000, 0, 1, 0, "R7 spare limit+1 miss");
    send(64'h0000_7000_0000_0040, 0, 0, 0, "R7 spare in gvm64");
    idle(); idle();
    // R10 hold while idle
    @(negedge clk);
    n_cmp++;
    if (out_valid !== 1'b0 || out_addr !== last_exp.addr || out_mtype !== last_exp.mtype) begin
      n_bad++;
      $display("FAIL R10 hold: actual v=%0b addr=%h mt=%0d expected v=0 addr=%h mt=%0d",
               out_valid, out_addr, out_mtype, last_exp.addr, last_exp.mtype);
    end

    // spare covering the low 4 GB: R7 in sys32 never matches
    cfg_spare_base_hi = 48'h0; cfg_spare_limit_hi = 48'h0000_0000_FFFF;
    send(64'h0000_0000_0000_0040, 0, 1, 0, "R7 spare low sys64");
    send(64'h0000_0000_0000_0040, 0, 1, 1, "R7 no spare in sys32");
    idle();

    // R5 offset overflow with a wide aperture
    cfg_vm_limit_hi = 48'h0002_FFFF_FFFF;
    send(64'h0001_00FF_FFFF_FFFF, 0, 1, 0, "R5 offset 2^40-1 ok");
    send(64'h0001_0100_0000_0000, 0, 1, 0, "R5 offset 2^40 fault");
    idle();

    // R8 aperture reached through narrowed pointer
    cfg_vm_base_hi = 48'h0000_0000_8000; cfg_vm_limit_hi = 48'h0000_0000_FFFF;
    send(64'hFFFF_FFFF_8000_1000, 0, 1, 1, "R8 sys32 aperture hit");
    send(64'hFFFF_FFFF_8000_1000, 0, 1, 0, "R8 same ptr sys64 canonical");
    send(64'h0000_0000_7FFF_FFFF, 0, 1, 1, "R3 sys32 base-1");
    idle(); idle(); idle();
    check_bit(exp_q.size() == 0, 1'b1, "R9 all results returned");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule